// File: doc/BRIEF.md
# Configurable lookup-table logic slice

This block models one programmable logic cell holding two 4-input lookup tables. Each table has one truth-table bit per input combination. A shift chain or a single-cycle parallel write loads the tables, and they are then evaluated combinationally. A mode input chooses how the pair is used:

- as two independent 4-input functions;
- as a single 5-input function, with the fifth input selecting between the tables;
- as a 16-entry, 2-bit read-only table.

A fourth mode code stands for writable memory. This slice does not support that use, so it is refused and gives zero outputs.

The 5-input result also appears on a dedicated output, so neighbouring slices can cascade it into wider functions. Each of the two main outputs can be taken straight from the logic or from a flip-flop behind it. A configuration bit chooses this per output, and the flip-flops have a synchronous clear. All outputs stay at 0 until the configuration has been declared complete.

Top module: `lut_slice`

## Requirements
- R1: During and right after reset, `out0_o`, `out1_o`, `lut5_o` and `cfg_done_o` are 0.
- R2: While `cfg_en_i` is high and `cfg_load_i` is low, each clock shifts `cfg_ser_i` into bit 0 of the 34-bit configuration word, so the first bit sent ends up in bit 33. The word layout is: bits 33:18 hold table 1, bits 17:2 hold table 0 (bit 2+k is the entry for input value k), bit 1 enables the register on `out1_o`, and bit 0 enables the register on `out0_o`.
- R3: `cfg_load_i` writes `cfg_data_i` into the configuration word in one clock. It takes priority over a shift in the same cycle.
- R4: `cfg_done_i` sets `cfg_done_o` at the next clock unless a load or shift happens in that cycle. Any load or shift clears `cfg_done_o`. While `cfg_done_o` is 0, all three outputs are 0.
- R5: With mode 0 (dual), `out0_o` is table 0 at `a_i` and `out1_o` is table 1 at `b_i`. `lut5_o` is 0.
- R6: With mode 1 (5-input), both tables are read at `a_i`. `sel_i`=0 selects table 0 and `sel_i`=1 selects table 1. The result drives `lut5_o` combinationally and also feeds `out0_o`, while `out1_o` is 0.
- R7: With mode 2 (read-only table), both tables are read at the shared address `a_i`. `out0_o` gives table 0 and `out1_o` gives table 1. `lut5_o` is 0.
- R8: Mode 3 (writable memory) is refused: all three outputs are 0.
- R9: When its enable bit is set, `out0_o` or `out1_o` shows the value that its direct path had one clock earlier. `lut5_o` is never registered.
- R10: `sclr_i` high at a clock edge clears both output registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Serial shift enable |
| cfg_ser_i | input | 1 | Serial configuration bit |
| cfg_load_i | input | 1 | Parallel load strobe |
| cfg_data_i | input | 34 | Parallel configuration word |
| cfg_done_i | input | 1 | Marks the configuration complete |
| mode_i | input | 2 | 0 dual, 1 five-input, 2 read-only, 3 refused |
| sclr_i | input | 1 | Synchronous clear of the output registers |
| a_i | input | 4 | Address of table 0, and of table 1 in modes 1 and 2 |
| b_i | input | 4 | Address of table 1 in mode 0 |
| sel_i | input | 1 | Fifth input in mode 1 |
| out0_o | output | 1 | First function output |
| out1_o | output | 1 | Second function output |
| lut5_o | output | 1 | Combinational 5-input result for cascading |
| cfg_done_o | output | 1 | Configuration complete flag |

## Verification
A corrupted table bit appears on an output the first time that table entry is addressed. For that reason the stimulus sweeps every address in every mode, so each bit of both tables is visible within 16 cycles of a load. A wrong bit order in the serial chain moves truth-table entries to the wrong addresses or flips the register enables. The sweep after a serial load therefore exposes it. A stuck output register or a missed clear shows up one clock after the edge concerned, and a wrong done flag shows up as nonzero outputs in the same cycle.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL = 2'd0,
    MODE_LUT5 = 2'd1,
    MODE_ROM  = 2'd2,
    MODE_RAM  = 2'd3
  } slice_mode_e;

  function automatic int cfg_width(input int n_in);
    return 2 * (1 << n_in) + 2;
  endfunction
endpackage

// File: rtl/lut_slice_cfg.sv
module lut_slice_cfg #(
  parameter int CFG_W = 34
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_ser_i,
  input  logic             cfg_load_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  input  logic             cfg_done_i,
  output logic [CFG_W-1:0] cfg_q_o,
  output logic             done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q_o <= '0;
      done_o  <= 1'b0;
    end else begin
      if (cfg_load_i)    cfg_q_o <= cfg_data_i;
      else if (cfg_en_i) cfg_q_o <= {cfg_q_o[CFG_W-2:0], cfg_ser_i};
      if (cfg_load_i || cfg_en_i) done_o <= 1'b0;
      else if (cfg_done_i)        done_o <= 1'b1;
    end
  end
endmodule

// File: rtl/lut_slice_lut.sv
module lut_slice_lut #(
  parameter int N_IN = 4,
  localparam int TBL = 1 << N_IN
) (
  input  logic [TBL-1:0]  tbl_i,
  input  logic [N_IN-1:0] addr_i,
  output logic            y_o
);
  assign y_o = tbl_i[addr_i];
endmodule

// File: rtl/lut_slice_outreg.sv
module lut_slice_outreg #(
  parameter int N_OUT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclr_i,
  input  logic [N_OUT-1:0] d_i,
  input  logic [N_OUT-1:0] en_i,
  input  logic             done_i,
  output logic [N_OUT-1:0] y_o
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= 1'b0;
      else if (sclr_i) q <= 1'b0;
      else             q <= d_i[i];
    end
    assign y_o[i] = done_i & (en_i[i] ? q : d_i[i]);
  end
endmodule

// File: rtl/lut_slice.sv
module lut_slice
  import lut_slice_pkg::*;
#(
  parameter int N_IN = 4,
  localparam int TBL = 1 << N_IN,
  localparam int CFG_W = 2 * TBL + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cfg_ser_i,
  input  logic             cfg_load_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  input  logic             cfg_done_i,
  input  logic [1:0]       mode_i,
  input  logic             sclr_i,
  input  logic [N_IN-1:0]  a_i,
  input  logic [N_IN-1:0]  b_i,
  input  logic             sel_i,
  output logic             out0_o,
  output logic             out1_o,
  output logic             lut5_o,
  output logic             cfg_done_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             done;
  slice_mode_e      mode;
  logic [1:0]       lut_y;
  logic [N_IN-1:0]  addr [2];
  logic [1:0]       comb;
  logic             f5;

  assign mode = slice_mode_e'(mode_i);

  lut_slice_cfg #(.CFG_W(CFG_W)) u_cfg (
    .clk_i, .rst_ni, .cfg_en_i, .cfg_ser_i, .cfg_load_i, .cfg_data_i,
    .cfg_done_i, .cfg_q_o(cfg_q), .done_o(done)
  );

  // table 1 follows b only in dual mode
  assign addr[0] = a_i;
  assign addr[1] = (mode == MODE_DUAL) ? b_i : a_i;

  for (genvar t = 0; t < 2; t++) begin : g_lut
    lut_slice_lut #(.N_IN(N_IN)) u_lut (
      .tbl_i(cfg_q[2 + t*TBL +: TBL]),
      .addr_i(addr[t]),
      .y_o(lut_y[t])
    );
  end

  assign f5 = sel_i ? lut_y[1] : lut_y[0];

  always_comb begin
    comb = 2'b00;
    unique case (mode)
      MODE_DUAL, MODE_ROM: comb = lut_y;
      MODE_LUT5:           comb = {1'b0, f5};
      default:             comb = 2'b00;
    endcase
    comb = done ? comb : 2'b00;
  end

  lut_slice_outreg #(.N_OUT(2)) u_oreg (
    .clk_i, .rst_ni, .sclr_i,
    .d_i(comb), .en_i(cfg_q[1:0]), .done_i(done),
    .y_o({out1_o, out0_o})
  );

  assign lut5_o     = done & (mode == MODE_LUT5) & f5;
  assign cfg_done_o = done;
endmodule

// File: rtl/lut_slice_chk.sv
module lut_slice_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_en_i,
  input logic       cfg_load_i,
  input logic       cfg_done_i,
  input logic [1:0] mode_i,
  input logic       out0_o,
  input logic       out1_o,
  input logic       lut5_o,
  input logic       cfg_done_o
);
  // R4
  not_done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_done_o |-> (!out0_o && !out1_o && !lut5_o));
  // R4
  load_clears_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_load_i || cfg_en_i) |=> !cfg_done_o);
  // R4
  done_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_done_i && !cfg_load_i && !cfg_en_i) |=> cfg_done_o);
  // R8
  ram_refused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3) |-> (!lut5_o && (cfg_done_o || !out0_o)));
  // R6
  lut5_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd1) |-> !lut5_o);
endmodule

bind lut_slice lut_slice_chk u_chk (.*);

// File: tb/lut_slice_tb.sv
module lut_slice_tb;
  localparam int TBL = 16;
  localparam int CFG_W = 2 * TBL + 2;

  logic clk = 0, rst_ni = 0;
  logic cfg_en = 0, cfg_ser = 0, cfg_load = 0, cfg_done = 0, sclr = 0, sel = 0;
  logic [CFG_W-1:0] cfg_data = '0;
  logic [1:0] mode = 0;
  logic [3:0] a = 0, b = 0;
  logic out0, out1, lut5, done_o;

  int n_vec = 0, n_bad = 0;
  string req = "R1";

  logic [CFG_W-1:0] m_cfg = '0;
  bit m_done = 0, m_q0 = 0, m_q1 = 0;
  bit c0, c1, c5;

  always #2 clk = ~clk;

  lut_slice u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_en_i(cfg_en), .cfg_ser_i(cfg_ser),
    .cfg_load_i(cfg_load), .cfg_data_i(cfg_data), .cfg_done_i(cfg_done),
    .mode_i(mode), .sclr_i(sclr), .a_i(a), .b_i(b), .sel_i(sel),
    .out0_o(out0), .out1_o(out1), .lut5_o(lut5), .cfg_done_o(done_o)
  );

  function automatic bit tb_entry(int t, int idx);
    return m_cfg[2 + t*TBL + idx];
  endfunction

  task automatic model_comb();
    bit l0, l1;
    l0 = tb_entry(0, int'(a));
    l1 = tb_entry(1, (mode == 0) ? int'(b) : int'(a));
    c0 = 0; c1 = 0; c5 = 0;
    case (mode)
      2'd0, 2'd2: begin c0 = l0; c1 = l1; end
      2'd1: begin c0 = sel ? l1 : l0; c5 = c0; end
      default: ;
    endcase
    if (!m_done) begin c0 = 0; c1 = 0; c5 = 0; end
  endtask

  task automatic compare();
    bit e0, e1;
    model_comb();
    e0 = m_done & (m_cfg[0] ? m_q0 : c0);
    e1 = m_done & (m_cfg[1] ? m_q1 : c1);
    n_vec++;
    if ({out0, out1, lut5, done_o} !== {e0, e1, c5, m_done}) begin
      n_bad++;
      $display("FAIL %s: out0/out1/lut5/done = %b%b%b%b expected %b%b%b%b",
               req, out0, out1, lut5, done_o, e0, e1, c5, m_done);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    @(posedge clk);
    if (rst_ni) begin
      m_q0 = sclr ? 0 : c0;
      m_q1 = sclr ? 0 : c1;
      if (cfg_load)    m_cfg = cfg_data;
      else if (cfg_en) m_cfg = {m_cfg[CFG_W-2:0], cfg_ser};
      if (cfg_load || cfg_en) m_done = 0;
      else if (cfg_done)      m_done = 1;
    end
    #1;
  endtask

  task automatic serial_load(logic [CFG_W-1:0] w);
    req = "R2";
    cfg_en = 1;
    for (int i = CFG_W - 1; i >= 0; i--) begin
      cfg_ser = w[i];
      tick();
    end
    cfg_en = 0;
    cfg_done = 1;
    req = "R4";
    tick();
    cfg_done = 0;
  endtask

  task automatic sweep(string r, logic [1:0] md);
    req = r;
    mode = md;
    for (int i = 0; i < 32; i++) begin
      a = i[3:0];
      b = 4'(i * 7 + 3);
      sel = i[4];
      tick();
    end
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    req = "R1";
    tick(); tick();
    @(negedge clk); rst_ni = 1;
    tick();
    // outputs held at 0 before configuration
    req = "R4";
    mode = 0; a = 4'hF; tick();
    serial_load({16'hA5C3, 16'h6996, 2'b00});
    sweep("R5", 2'd0);
    sweep("R6", 2'd1);
    sweep("R7", 2'd2);
    sweep("R8", 2'd3);
    // parallel load wins over a concurrent shift; enable both registers
    req = "R3";
    cfg_data = {16'h1234, 16'hF00D, 2'b11};
    cfg_load = 1; cfg_en = 1; cfg_ser = 1;
    tick();
    cfg_load = 0; cfg_en = 0;
    req = "R4";
    mode = 0; a = 4'h2; tick();
    cfg_done = 1; tick(); cfg_done = 0;
    sweep("R9", 2'd0);
    sweep("R9", 2'd1);
    sweep("R9", 2'd2);
    req = "R10";
    mode = 2; a = 4'h0;
    for (int i = 0; i < 12; i++) begin
      a = 4'(i);
      sclr = i[1];
      tick();
    end
    sclr = 0;
    // new load while in use drops outputs to 0
    req = "R4";
    cfg_data = {16'hFFFF, 16'hFFFF, 2'b00};
    cfg_load = 1; tick(); cfg_load = 0;
    tick(); tick();
    cfg_done = 1; tick(); cfg_done = 0;
    sweep("R5", 2'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule